// File: doc/BRIEF.md
# DMA Trigger Capture and Missed-Trigger Detector

This block sits at the front of a multi-channel DMA channel controller. Each channel can be started by four kinds of trigger pulse: a peripheral request, a software request, a chain request raised when an earlier transfer finishes, and a quick-DMA request. Each accepted trigger takes a one-entry slot for its channel and kind. A channel's pending bit is set while any of its slots holds an event, or while the channel is stuck. Queued events leave through a valid/ready dequeue port toward the transfer-submission logic. The port carries the channel number and the trigger kind.

A trigger that cannot be taken is dropped and marks the channel's missed bit. This happens when its slot is still occupied, or when the channel is stuck. A channel becomes stuck when one of its events is dequeued while the channel's parameter set is flagged NULL. Only a software release of the pending bit unsticks it. All missed bits, gated by one enable, drive a single error interrupt that every processor shares.

Back-pressure rules on the dequeue port: an offer, once made, stays unchanged in channel and kind until `deq_ready_i` is seen high at a clock edge. The slot it names stays occupied until that handshake edge. The NULL flag of the offered channel is sampled at the handshake edge.

Top module: `dmaev_latch`

## Requirements
- R1: After reset, all pending and missed bits are 0, `deq_valid_o` is 0 and `err_irq_o` is 0.
- R2: A trigger accepted at a clock edge sets the channel's bit in `sec_o` after that edge. The event is offered on the dequeue port no earlier than one edge later, and only while its slot is occupied.
- R3: A handshake on a channel whose NULL flag is low empties that slot at the edge, with no missed bit. `sec_o` falls if no other slot of the channel is occupied.
- R4: A trigger whose channel-and-kind slot is occupied at the edge sets the channel's missed bit and is dropped. This includes a trigger in the same cycle as that slot's handshake. The dropped trigger produces no extra dequeue.
- R5: A trigger of a different kind from the events already queued on a channel is accepted into its own slot and sets no missed bit.
- R6: A handshake while the offered channel's NULL flag is high sets the channel's missed bit and makes it stuck. `sec_o` stays set, and every later trigger of any kind on that channel is counted missed and dropped until a release.
- R7: `sec_clr_i[c]` (write 1 to clear, applied at the next edge) releases a stuck channel 'c'. A trigger arriving on that channel in the same cycle as the release is accepted and not counted missed.
- R8: `miss_clr_i[c]` clears missed bit 'c' at the next edge. A missed trigger on the same channel in the same cycle wins, and the bit stays set.
- R9: A set missed bit does not block the channel: a later trigger on a free slot is accepted and dequeued.
- R10: `err_irq_o` is high exactly when `err_en_i` is high and any missed bit is set.
- R11: Among occupied slots, the offer goes to the lowest channel number. Within a channel, kinds are ordered peripheral (code 0), software (1), chain (2), quick (3). `deq_type_o` carries that code.
- R12: While `deq_valid_o` is high and `deq_ready_i` is low, the offer stays valid with `deq_chan_o` and `deq_type_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_periph_i | input | NCH | Peripheral trigger pulse per channel |
| trig_sw_i | input | NCH | Software trigger pulse per channel |
| trig_chain_i | input | NCH | Chain trigger pulse per channel |
| trig_quick_i | input | NCH | Quick-DMA trigger pulse per channel |
| null_pset_i | input | NCH | Channel parameter set is NULL |
| sec_clr_i | input | NCH | Write-1-to-clear of pending bits (releases stuck channel) |
| miss_clr_i | input | NCH | Write-1-to-clear of missed bits |
| err_en_i | input | 1 | Error interrupt enable |
| deq_ready_i | input | 1 | Consumer accepts the offered event |
| deq_valid_o | output | 1 | An event is offered |
| deq_chan_o | output | $clog2(NCH) | Channel of the offered event |
| deq_type_o | output | 2 | Trigger kind code of the offered event |
| sec_o | output | NCH | Pending bit per channel |
| miss_o | output | NCH | Missed bit per channel |
| err_irq_o | output | 1 | Shared error interrupt |

## Verification
Two same-kind triggers in a row on one channel are set against a peripheral trigger followed by a chain trigger. This separates per-kind missed detection from a per-channel one. Bursts across several channels with the consumer stalled show the priority order and whether the held offer stays stable. A NULL-flagged channel, driven through dequeue, more triggers, and then a release coinciding with a trigger, tells a stuck channel apart from one that is merely missed. Long random runs with random ready, clears and NULL flags mix all of these corner cases together.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;
  localparam int NTYPE = 4;
  localparam int TYW   = 2;
  typedef enum logic [TYW-1:0] {
    EV_PERIPH = 2'd0,
    EV_SW     = 2'd1,
    EV_CHAIN  = 2'd2,
    EV_QUICK  = 2'd3
  } ev_type_e;
endpackage

// File: rtl/dmaev_chan.sv
module dmaev_chan
  import dmaev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTYPE-1:0] trig_i,
  input  logic [NTYPE-1:0] deq_hit_i,
  input  logic             null_i,
  input  logic             sec_clr_i,
  input  logic             miss_clr_i,
  output logic [NTYPE-1:0] slot_o,
  output logic             sec_o,
  output logic             miss_o
);
  logic [NTYPE-1:0] slot_q;
  logic [NTYPE-1:0] miss_hit;
  logic             stuck_q;
  logic             stuck_eff;
  logic             deq_any;
  logic             deq_null;

  assign stuck_eff = stuck_q & ~sec_clr_i;
  assign deq_any   = |deq_hit_i;
  assign deq_null  = deq_any & null_i;

  for (genvar t = 0; t < NTYPE; t++) begin : g_slot
    logic busy;
    assign busy        = slot_q[t] | stuck_eff;
    assign miss_hit[t] = trig_i[t] & busy;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[t] <= 1'b0;
      else if (trig_i[t] && !busy)
        slot_q[t] <= 1'b1;
      else if (deq_hit_i[t])
        slot_q[t] <= 1'b0;
    end

    assert_dup_missed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i[t] && slot_q[t] |=> miss_o);
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      deq_hit_i[t] && !null_i |=> !slot_q[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stuck_q <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      stuck_q <= stuck_eff | deq_null;
      miss_o  <= (miss_o & ~miss_clr_i) | (|miss_hit) | deq_null;
    end
  end

  assign slot_o = slot_q;
  assign sec_o  = stuck_q | (|slot_q);

  assert_stuck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deq_null |=> sec_o && miss_o);
  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_q && !sec_clr_i && (|trig_i) |=> miss_o);
endmodule

// File: rtl/dmaev_arb.sv
module dmaev_arb #(
  parameter int NREQ = 32,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o,
  output logic            hs_o
);
  logic [NREQ-1:0] cand;
  logic            pick_any;
  logic [IW-1:0]   pick;
  logic            load;

  always_comb begin
    cand = req_i;
    if (valid_o) cand[idx_o] = 1'b0;
  end

  always_comb begin
    pick_any = 1'b0;
    pick     = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_any = 1'b1;
        pick     = IW'(i);
      end
    end
  end

  assign load = !valid_o || ready_i;
  assign hs_o = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else if (load) begin
      valid_o <= pick_any;
      idx_o   <= pick;
    end
  end

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(idx_o));
endmodule

// File: rtl/dmaev_latch.sv
module dmaev_latch
  import dmaev_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         trig_periph_i,
  input  logic [NCH-1:0]         trig_sw_i,
  input  logic [NCH-1:0]         trig_chain_i,
  input  logic [NCH-1:0]         trig_quick_i,
  input  logic [NCH-1:0]         null_pset_i,
  input  logic [NCH-1:0]         sec_clr_i,
  input  logic [NCH-1:0]         miss_clr_i,
  input  logic                   err_en_i,
  input  logic                   deq_ready_i,
  output logic                   deq_valid_o,
  output logic [$clog2(NCH)-1:0] deq_chan_o,
  output logic [TYW-1:0]         deq_type_o,
  output logic [NCH-1:0]         sec_o,
  output logic [NCH-1:0]         miss_o,
  output logic                   err_irq_o
);
  localparam int CHW  = $clog2(NCH);
  localparam int NREQ = NCH * NTYPE;
  localparam int IW   = CHW + TYW;

  logic [NREQ-1:0] slot_all;
  logic [IW-1:0]   idx;
  logic            hs;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NTYPE-1:0] trig_v;
    logic [NTYPE-1:0] hit_v;
    assign trig_v = {trig_quick_i[c], trig_chain_i[c], trig_sw_i[c], trig_periph_i[c]};
    for (genvar t = 0; t < NTYPE; t++) begin : g_hit
      assign hit_v[t] = hs && (idx == IW'(c * NTYPE + t));
    end
    dmaev_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig_v),
      .deq_hit_i  (hit_v),
      .null_i     (null_pset_i[c]),
      .sec_clr_i  (sec_clr_i[c]),
      .miss_clr_i (miss_clr_i[c]),
      .slot_o     (slot_all[c*NTYPE +: NTYPE]),
      .sec_o      (sec_o[c]),
      .miss_o     (miss_o[c])
    );
  end

  dmaev_arb #(.NREQ(NREQ), .IW(IW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (slot_all),
    .ready_i (deq_ready_i),
    .valid_o (deq_valid_o),
    .idx_o   (idx),
    .hs_o    (hs)
  );

  assign deq_chan_o = idx[IW-1:TYW];
  assign deq_type_o = idx[TYW-1:0];
  assign err_irq_o  = err_en_i & (|miss_o);

  assert_offer_queued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid_o |-> slot_all[idx]);
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> err_en_i && miss_o != '0);
endmodule

// File: tb/sim_dmaev_latch.sv
module sim_dmaev_latch;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] t_per = '0, t_sw = '0, t_chn = '0, t_qk = '0;
  logic [NCH-1:0] nul = '0, sclr = '0, mclr = '0;
  logic err_en = 1'b1, ready = 1'b0;
  logic deq_valid, err_irq;
  logic [2:0] deq_chan;
  logic [1:0] deq_type;
  logic [NCH-1:0] sec, miss;

  int vectors = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  dmaev_latch #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .trig_periph_i(t_per), .trig_sw_i(t_sw), .trig_chain_i(t_chn), .trig_quick_i(t_qk),
    .null_pset_i(nul), .sec_clr_i(sclr), .miss_clr_i(mclr), .err_en_i(err_en),
    .deq_ready_i(ready), .deq_valid_o(deq_valid), .deq_chan_o(deq_chan),
    .deq_type_o(deq_type), .sec_o(sec), .miss_o(miss), .err_irq_o(err_irq)
  );

  // behavioural reference
  bit mq [NCH][4];
  bit mstuck [NCH];
  bit mmiss [NCH];
  bit mvld;
  int midx;

  function automatic bit trg(int c, int t);
    case (t)
      0: return t_per[c];
      1: return t_sw[c];
      2: return t_chn[c];
      default: return t_qk[c];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mq[c, t]) mq[c][t] = 0;
      foreach (mstuck[c]) begin mstuck[c] = 0; mmiss[c] = 0; end
      mvld = 0; midx = 0;
    end else begin
      bit hs;
      int pick;
      bit nq [NCH][4];
      bit ns [NCH];
      bit nm [NCH];
      hs = mvld && ready;
      pick = -1;
      for (int i = NCH * 4 - 1; i >= 0; i--)
        if (mq[i / 4][i % 4] && !(mvld && i == midx)) pick = i;
      for (int c = 0; c < NCH; c++) begin
        bit stuck_now, dq_here, missed;
        stuck_now = mstuck[c] && !sclr[c];
        dq_here = hs && (midx / 4 == c);
        missed = 0;
        for (int t = 0; t < 4; t++) begin
          bit busy;
          busy = mq[c][t] || stuck_now;
          nq[c][t] = mq[c][t];
          if (trg(c, t) && busy) missed = 1;
          if (trg(c, t) && !busy) nq[c][t] = 1;
          else if (dq_here && midx % 4 == t) nq[c][t] = 0;
        end
        ns[c] = stuck_now || (dq_here && nul[c]);
        nm[c] = (mmiss[c] && !mclr[c]) || missed || (dq_here && nul[c]);
      end
      foreach (mq[c, t]) mq[c][t] = nq[c][t];
      foreach (mstuck[c]) begin mstuck[c] = ns[c]; mmiss[c] = nm[c]; end
      if (!mvld || ready) begin
        mvld = (pick >= 0);
        if (pick >= 0) midx = pick;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #5;
    begin
      logic [NCH-1:0] es, em;
      for (int c = 0; c < NCH; c++) begin
        es[c] = mstuck[c] || mq[c][0] || mq[c][1] || mq[c][2] || mq[c][3];
        em[c] = mmiss[c];
      end
      if (!rst_n) begin
        check("R1 reset sec_o", int'(sec), 0);
        check("R1 reset deq_valid_o", int'(deq_valid), 0);
      end else begin
        check("R2 R3 R6 R7 sec_o", int'(sec), int'(es));
        check("R4 R5 R6 R8 R9 miss_o", int'(miss), int'(em));
        check("R10 err_irq_o", int'(err_irq), int'(err_en && em != 0));
        check("R2 R12 deq_valid_o", int'(deq_valid), int'(mvld));
        if (mvld) begin
          check("R11 R12 deq_chan_o", int'(deq_chan), midx / 4);
          check("R11 R12 deq_type_o", int'(deq_type), midx % 4);
        end
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t_per = '0; t_sw = '0; t_chn = '0; t_qk = '0; sclr = '0; mclr = '0;
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;                       // R1 observed during reset
    cyc();
    // R5: peripheral then chain on ch2, no missed bit; R4: second peripheral missed
    t_per[2] = 1; cyc();
    t_chn[2] = 1; cyc();
    t_per[2] = 1; cyc(2);
    // R3: drain with valid parameter sets
    ready = 1; cyc(4);
    // R8: clear missed bit, then clear colliding with a missed trigger
    mclr[2] = 1; cyc(2);
    ready = 0; t_sw[4] = 1; cyc();
    t_sw[4] = 1; mclr[4] = 1; cyc(2);
    // R10: enable gates the interrupt
    err_en = 0; cyc(2); err_en = 1; cyc();
    // R11 R12: burst with consumer stalled
    t_qk[5] = 1; t_per[5] = 1; t_sw[1] = 1; t_chn[0] = 1; cyc(4);
    ready = 1; cyc(8);
    // R9: missed bit set yet channel still accepts
    t_sw[4] = 1; cyc(3);
    // R6: NULL hit makes ch3 stuck
    nul[3] = 1; t_per[3] = 1; cyc(4);
    nul[3] = 0; t_sw[3] = 1; cyc(); t_qk[3] = 1; cyc(2);
    // R7: release with simultaneous trigger
    sclr[3] = 1; t_chn[3] = 1; cyc(4);
    sclr[3] = 1; cyc(2);
    // R4: trigger in the cycle of its own handshake
    ready = 0; t_per[6] = 1; cyc(3);
    ready = 1; t_per[6] = 1; cyc(3);
    mclr = '1; cyc(2);
    // random mix
    for (int k = 0; k < 6000; k++) begin
      t_per = $urandom & $urandom & $urandom;
      t_sw  = $urandom & $urandom & $urandom & $urandom;
      t_chn = $urandom & $urandom & $urandom;
      t_qk  = $urandom & $urandom & $urandom & $urandom;
      ready = ($urandom % 3) != 0;
      if ($urandom % 16 == 0) nul = $urandom & $urandom & $urandom;
      sclr = ($urandom % 8 == 0) ? NCH'($urandom) : '0;
      mclr = ($urandom % 6 == 0) ? NCH'($urandom) : '0;
      err_en = ($urandom % 10) != 0;
      @(negedge clk);
    end
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule